// File: doc/BRIEF.md
# RTC Alarm and Interrupt Controller

This block sits beside the time-keeping counters of a real-time clock. It holds three interrupt sources: an alarm, a periodic tick and the end of each once-per-second update. It latches an event from each source into a flag, gates each flag with its enable, and pulls one active-low interrupt line while any enabled flag is set. Software reads the flags through a read strobe. The read returns the current flag byte and then clears every flag in that same access.

The alarm comparison looks at the seconds, minutes and hours bytes against three alarm bytes. Each alarm byte can be set to a wildcard code that matches anything. The comparison is made only when the counters report a finished update, so each matching second gives exactly one event. The block also owns two control bits. One is the update-ended interrupt enable, which is dropped when the freeze bit rises. The other is the square-wave output enable, which comes up set. The block gates an externally supplied rate waveform onto the square-wave pin.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: On a cycle where `upd_done` is 1 and every alarm byte matches its time byte, the alarm flag (`flag_view` bit 1) is set from the next cycle on. A match seen while `upd_done` is 0 sets nothing.
- R2: An alarm byte whose bits [7:6] are 2'b11 matches any value of its time byte. An alarm byte without that code must equal its time byte exactly, so one differing byte stops the alarm event.
- R3: The alarm flag pulls `irq_n` low only while `alm_en` is 1. With `alm_en` at 0 the flag still sets and `irq_n` stays 1.
- R4: A `per_tick` pulse sets the periodic flag (`flag_view` bit 2) whatever the value of `per_en`. That flag pulls `irq_n` low only while `per_en` is 1.
- R5: An `upd_done` pulse sets the update-ended flag (`flag_view` bit 0). That flag pulls `irq_n` low only while the update interrupt enable (`ctl_view` bit 0) is 1.
- R6: A rising edge of `freeze` clears the update interrupt enable one cycle later. This holds even when a control write sets the enable in that same cycle.
- R7: `irq_n` is 0 exactly when some flag is set together with its enable. `flag_view` bit 3 is the inverse of `irq_n`.
- R8: While `flag_rd` is 1, `flag_view` shows the flags as they stand. From the next cycle all three flags are 0 and `irq_n` returns to 1.
- R9: A flag event in the same cycle as `flag_rd` wins over the clear, so that flag reads 1 after the access.
- R10: With the square-wave enable (`ctl_view` bit 1) at 1 and `fast_sel` at 0, `sqw_out` follows `rate_wave` one cycle later. With the enable at 0, or with `fast_sel` at 1, `sqw_out` is 0.
- R11: After reset all flags are 0, `irq_n` is 1, the update interrupt enable is 0 and the square-wave enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| upd_done | input | 1 | One-cycle strobe at the end of each update |
| per_tick | input | 1 | One-cycle strobe at the selected periodic rate |
| rate_wave | input | 1 | Rate-selected square-wave source |
| freeze | input | 1 | Freeze bit; its rising edge drops the update interrupt enable |
| per_en | input | 1 | Periodic interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| fast_sel | input | 1 | High-frequency output select; when 1 this block drives the pin low |
| ctl_we | input | 1 | Write strobe for the two held control bits |
| ctl_upd_en_wr | input | 1 | Value written to the update interrupt enable |
| ctl_sqw_en_wr | input | 1 | Value written to the square-wave enable |
| flag_rd | input | 1 | Flag read strobe; clears the flags after the access |
| flag_view | output | 4 | {irq summary, periodic, alarm, update-ended} |
| ctl_view | output | 2 | {square-wave enable, update interrupt enable} |
| irq_n | output | 1 | Interrupt, active low |
| sqw_out | output | 1 | Square-wave output pin |

## Verification
Two pairs of actions can meet in one cycle. The first is a flag read with a new flag event. The bench raises `flag_rd` in the same cycle as a `per_tick`, and in another case in the same cycle as an `upd_done` that also carries an alarm match. It expects the flags of those events to survive the read and every other flag to drop. The second is a rising `freeze` in the same cycle as a control write that sets the update interrupt enable. For that case the bench reads `ctl_view` and expects the enable to be 0.

// File: rtl/rtc_irq_pkg.sv
// Package: shared widths, flag positions and the alarm wildcard code.
// Assumes time bytes are eight bits wide; the wildcard sits in the top two.
package rtc_irq_pkg;
    localparam int BYTE_W      = 8;
    localparam int NUM_FIELDS  = 3;
    localparam int NUM_FLAGS   = 3;
    localparam int FLG_UPD     = 0;
    localparam int FLG_ALM     = 1;
    localparam int FLG_PER     = 2;
    localparam logic [1:0] WILDCARD = 2'b11;
endpackage

// File: rtl/rtc_alarm_cmp.sv
// Module: compares each time field with its alarm byte and reports a match
// when every field either agrees or carries the wildcard code in its top bits.
// Assumes fields are packed lowest-index first.
module rtc_alarm_cmp
    import rtc_irq_pkg::*;
#(
    parameter int W = BYTE_W,
    parameter int N = NUM_FIELDS
) (
    input  logic [N*W-1:0] cur_fields,
    input  logic [N*W-1:0] alm_fields,
    output logic           all_match
);
    logic [N-1:0] field_ok;

    for (genvar g = 0; g < N; g++) begin : g_field
        logic [W-1:0] c_b, a_b;
        assign c_b = cur_fields[g*W +: W];
        assign a_b = alm_fields[g*W +: W];
        // Per-field match: wildcard or exact equality.
        always_comb begin
            field_ok[g] = (a_b[W-1 -: 2] == WILDCARD) || (a_b == c_b);
        end
    end

    assign all_match = &field_ok;
endmodule

// File: rtl/rtc_flag_bank.sv
// Module: holds the interrupt flags. Events set them, and a read strobe
// clears them after the access. An event in the read cycle survives.
// Assumes events are one-cycle strobes.
module rtc_flag_bank
    import rtc_irq_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         rd_clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flag_q;

    // Flag update: clear on read, then OR in fresh events.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (rd_clr ? '0 : flag_q) | evt;
    end

    assign flags = flag_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R8: a read without a coinciding event leaves the flag clear.
        a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && !evt[i]) |=> !flag_q[i]);
        // R9: an event always shows as set in the following cycle.
        a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flag_q[i]);
    end
endmodule

// File: rtl/rtc_sqw_gate.sv
// Module: registers the square-wave pin. It passes the rate waveform when
// enabled and the high-frequency select is off, and holds the pin low otherwise.
module rtc_sqw_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sqw_en,
    input  logic fast_sel,
    input  logic rate_wave,
    output logic sqw_out
);
    logic sqw_q;

    // Pin register: gated copy of the rate waveform.
    always_ff @(posedge clk) begin
        if (!rst_n) sqw_q <= 1'b0;
        else        sqw_q <= sqw_en && !fast_sel && rate_wave;
    end

    assign sqw_out = sqw_q;

    // R10: a disabled output is low in the following cycle.
    a_r10_sqw_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!sqw_en || fast_sel) |=> !sqw_out);
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Module: top of the alarm and interrupt controller. It builds the three
// flag events, holds the update interrupt and square-wave enables, and
// drives the active-low interrupt. Assumes upd_done and per_tick are
// one-cycle strobes from the time-keeping chain.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_sec,
    input  logic [W-1:0] cur_min,
    input  logic [W-1:0] cur_hour,
    input  logic [W-1:0] alm_sec,
    input  logic [W-1:0] alm_min,
    input  logic [W-1:0] alm_hour,
    input  logic         upd_done,
    input  logic         per_tick,
    input  logic         rate_wave,
    input  logic         freeze,
    input  logic         per_en,
    input  logic         alm_en,
    input  logic         fast_sel,
    input  logic         ctl_we,
    input  logic         ctl_upd_en_wr,
    input  logic         ctl_sqw_en_wr,
    input  logic         flag_rd,
    output logic [3:0]   flag_view,
    output logic [1:0]   ctl_view,
    output logic         irq_n,
    output logic         sqw_out
);
    logic                 match_all;
    logic [NUM_FLAGS-1:0] evt, flags, en_vec;
    logic                 upd_en_q, sqw_en_q, freeze_q;
    logic                 irq_any;

    rtc_alarm_cmp #(.W(W), .N(NUM_FIELDS)) u_cmp (
        .cur_fields ({cur_hour, cur_min, cur_sec}),
        .alm_fields ({alm_hour, alm_min, alm_sec}),
        .all_match  (match_all)
    );

    // Event vector: the alarm is sampled only on a finished update.
    always_comb begin
        evt          = '0;
        evt[FLG_UPD] = upd_done;
        evt[FLG_ALM] = upd_done && match_all;
        evt[FLG_PER] = per_tick;
    end

    rtc_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .rd_clr (flag_rd),
        .flags  (flags)
    );

    // Control bits: written by software, and the update enable is dropped when freeze rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_en_q <= 1'b0;
            sqw_en_q <= 1'b1;
            freeze_q <= 1'b0;
        end else begin
            freeze_q <= freeze;
            if (ctl_we) begin
                upd_en_q <= ctl_upd_en_wr;
                sqw_en_q <= ctl_sqw_en_wr;
            end
            if (freeze && !freeze_q) upd_en_q <= 1'b0;
        end
    end

    // Enable mask lined up with the flag positions.
    always_comb begin
        en_vec          = '0;
        en_vec[FLG_UPD] = upd_en_q;
        en_vec[FLG_ALM] = alm_en;
        en_vec[FLG_PER] = per_en;
    end

    assign irq_any   = |(flags & en_vec);
    assign irq_n     = !irq_any;
    assign flag_view = {irq_any, flags};
    assign ctl_view  = {sqw_en_q, upd_en_q};

    rtc_sqw_gate u_sqw (
        .clk       (clk),
        .rst_n     (rst_n),
        .sqw_en    (sqw_en_q),
        .fast_sel  (fast_sel),
        .rate_wave (rate_wave),
        .sqw_out   (sqw_out)
    );

    // R6: a rising freeze leaves the update enable at 0 in the next cycle.
    a_r6_freeze_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze) |=> !ctl_view[0]);
    // R1: a full match on an update strobe sets the alarm flag.
    a_r1_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && match_all) |=> flag_view[FLG_ALM]);
    // R1: without an update strobe, a clear alarm flag stays clear unless no read... only for no event.
    a_r1_no_strobe_no_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_done && !flag_view[FLG_ALM]) |=> !flag_view[FLG_ALM]);
    // R3: a masked alarm never pulls the interrupt low by itself.
    a_r3_alarm_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_en && !per_en && !ctl_view[0]) |-> irq_n);
endmodule

// File: tb/tb_rtc_irq_ctrl.sv
module tb_rtc_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n;
    logic [7:0] cur_sec, cur_min, cur_hour, alm_sec, alm_min, alm_hour;
    logic upd_done, per_tick, rate_wave, freeze, per_en, alm_en, fast_sel;
    logic ctl_we, ctl_upd_en_wr, ctl_sqw_en_wr, flag_rd;
    logic [3:0] flag_view;
    logic [1:0] ctl_view;
    logic irq_n, sqw_out;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    rtc_irq_ctrl dut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic clear_flags();
        tick(); flag_rd = 1'b1;
        tick(); flag_rd = 1'b0;
    endtask

    task automatic pulse_upd();
        tick(); upd_done = 1'b1;
        tick(); upd_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
        check("R11 flags", {4'h0, flag_view}, 8'h00);
        check("R11 ctl", {6'h0, ctl_view}, 8'h02);
        check("R11 irq_n", {7'h0, irq_n}, 8'h01);
    endtask

    task automatic t_alarm_exact();
        cur_sec = 8'h30; cur_min = 8'h15; cur_hour = 8'h09;
        alm_sec = 8'h30; alm_min = 8'h15; alm_hour = 8'h09;
        alm_en = 1'b1;
        tick(); tick();
        check("R1 no strobe no alarm", {4'h0, flag_view}, 8'h00);
        pulse_upd();
        check("R1 alarm+upd flags", {4'h0, flag_view}, 8'h0B);
        check("R7 irq_n low", {7'h0, irq_n}, 8'h00);
        clear_flags();
    endtask

    task automatic t_wildcard();
        alm_sec = 8'hC0; alm_min = 8'hFF; alm_hour = 8'h09;
        cur_sec = 8'h47; cur_min = 8'h22;
        pulse_upd();
        check("R2 wildcard match", {4'h0, flag_view}, 8'h0B);
        clear_flags();
        cur_hour = 8'h10;
        pulse_upd();
        check("R2 hour mismatch", {7'h0, flag_view[1]}, 8'h00);
        check("R7 upd flag only, masked", {4'h0, flag_view}, 8'h01);
        clear_flags();
        cur_hour = 8'h09;
    endtask

    task automatic t_alarm_masked();
        alm_en = 1'b0;
        pulse_upd();
        check("R3 flag sets when masked", {7'h0, flag_view[1]}, 8'h01);
        check("R3 irq_n stays high", {7'h0, irq_n}, 8'h01);
        clear_flags();
    endtask

    task automatic t_periodic();
        per_en = 1'b0;
        tick(); per_tick = 1'b1; tick(); per_tick = 1'b0;
        check("R4 periodic flag masked", {4'h0, flag_view}, 8'h04);
        check("R4 irq_n masked", {7'h0, irq_n}, 8'h01);
        tick(); per_en = 1'b1; #1;
        check("R7 summary bit", {4'h0, flag_view}, 8'h0C);
        check("R4 irq_n enabled", {7'h0, irq_n}, 8'h00);
        tick(); flag_rd = 1'b1; #1;
        check("R8 read shows flags", {4'h0, flag_view}, 8'h0C);
        tick(); flag_rd = 1'b0;
        check("R8 cleared after read", {4'h0, flag_view}, 8'h00);
        check("R8 irq released", {7'h0, irq_n}, 8'h01);
        per_en = 1'b0;
    endtask

    task automatic t_coincide();
        tick(); per_tick = 1'b1; tick(); per_tick = 1'b0;
        tick(); upd_done = 1'b1; flag_rd = 1'b1;
        tick(); upd_done = 1'b0; flag_rd = 1'b0;
        check("R9 event during read kept", {4'h0, flag_view}, 8'h03);
        tick(); flag_rd = 1'b1; per_tick = 1'b1;
        tick(); flag_rd = 1'b0; per_tick = 1'b0;
        check("R9 periodic kept, others cleared", {4'h0, flag_view}, 8'h04);
        clear_flags();
    endtask

    task automatic t_update_freeze();
        tick(); ctl_we = 1'b1; ctl_upd_en_wr = 1'b1; ctl_sqw_en_wr = 1'b1;
        tick(); ctl_we = 1'b0;
        check("R5 enable written", {6'h0, ctl_view}, 8'h03);
        pulse_upd();
        check("R5 irq from update", {7'h0, irq_n}, 8'h00);
        tick(); freeze = 1'b1;
        tick();
        check("R6 enable dropped", {6'h0, ctl_view}, 8'h02);
        check("R6 irq released", {7'h0, irq_n}, 8'h01);
        check("R5 flag kept", {7'h0, flag_view[0]}, 8'h01);
        tick(); freeze = 1'b0;
        tick(); freeze = 1'b1; ctl_we = 1'b1; ctl_upd_en_wr = 1'b1;
        tick(); ctl_we = 1'b0;
        check("R6 rise beats write", {6'h0, ctl_view}, 8'h02);
        freeze = 1'b0;
        clear_flags();
    endtask

    task automatic t_sqw();
        tick(); rate_wave = 1'b1; tick();
        check("R10 follows high", {7'h0, sqw_out}, 8'h01);
        rate_wave = 1'b0; tick();
        check("R10 follows low", {7'h0, sqw_out}, 8'h00);
        rate_wave = 1'b1; fast_sel = 1'b1; tick();
        check("R10 fast select low", {7'h0, sqw_out}, 8'h00);
        fast_sel = 1'b0; ctl_we = 1'b1; ctl_sqw_en_wr = 1'b0; ctl_upd_en_wr = 1'b0;
        tick(); ctl_we = 1'b0; tick();
        check("R10 disabled low", {7'h0, sqw_out}, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0;
        {cur_sec, cur_min, cur_hour, alm_sec, alm_min, alm_hour} = '0;
        {upd_done, per_tick, rate_wave, freeze, per_en, alm_en, fast_sel} = '0;
        {ctl_we, ctl_upd_en_wr, ctl_sqw_en_wr, flag_rd} = '0;
        t_reset();
        t_alarm_exact();
        t_wildcard();
        t_alarm_masked();
        t_periodic();
        t_coincide();
        t_update_freeze();
        t_sqw();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule